// File: doc/BRIEF.md
# Ethernet Transmit Frame Serializer

This block turns a frame held by a byte source into the serial bit stream that goes to the line interface. The source holds the destination address, source address, type/length and payload. The block sends one bit per clock and raises `tx_en` for the length of the frame. It puts seven 0x55 preamble bytes and the start-of-frame byte 0xD5 in front of the frame contents. When a frame asks for it, the block pads a short frame with 0x00 bytes up to a programmable minimum length. When a frame asks for it, the block appends the IEEE 802.3 CRC-32 check sequence. Every byte goes out least-significant bit first.

The byte source keeps its next unsent byte on `src_data`, with `src_last` marking the final byte. The block consumes that byte at the clock edge where `src_take` is high. While the first attempt of a frame runs, the block writes the first `REPLAY_DEPTH` bytes into a local replay store. After a `collision` abort, the controller starts the frame again with `frame_retry` set. The block then sends those first bytes from the store and fetches nothing from the source for them. The source only has to rewind to byte `REPLAY_DEPTH`.

The control is a state machine with six states. IDLE goes to PREAMBLE when it accepts `frame_start`. PREAMBLE goes to SFD after its seventh byte. SFD goes to DATA after the 0xD5 byte. When the last source byte ends, DATA goes to PAD if the frame is still short and padding is on, to FCS if the check sequence is requested, and to IDLE otherwise. PAD goes to FCS or to IDLE once the length is reached. FCS goes to IDLE after 32 bits. A `collision` in any state other than IDLE forces the machine to IDLE.

Top module: `eth_tx_serializer`

## Requirements
- R1: In the cycle after IDLE accepts `frame_start`, the line carries seven 0x55 bytes followed by one 0xD5 byte. Each byte goes out least-significant bit first, one bit per clock.
- R2: After 0xD5, the source bytes follow in order, each sent least-significant bit first. `src_take` is high for exactly one cycle per byte drawn from the source.
- R3: With `frame_pad` set, 0x00 bytes follow the source bytes until the count of bytes after 0xD5 reaches `min_len` minus 4. With `min_len` = 64, this gives a 46-byte data field.
- R4: With `frame_crc` set, the 32-bit complement of the reflected CRC-32 follows the last data or pad byte, bit 0 first. The CRC uses polynomial 0xEDB88320 with seed 0xFFFFFFFF and covers every byte from the destination address through the padding. With `frame_crc` clear, no check bits are sent.
- R5: `tx_en` is high from the first preamble bit through the last frame bit. It is low in the very next cycle.
- R6: No pad byte is sent when `frame_pad` is clear. No pad byte is sent when the source frame already has `min_len` minus 4 bytes or more.
- R7: A `frame_start` that arrives while a frame is in progress has no effect on the bits being sent.
- R8: A `collision` seen while `tx_en` is high drops `tx_en` in the next cycle and consumes no further source byte.
- R9: A frame started with `frame_retry` sends its first `REPLAY_DEPTH` bytes from the replay store without pulsing `src_take`. It then draws the remaining bytes from the source. This requires that the aborted attempt fetched at least `REPLAY_DEPTH` bytes and that the frame holds at least `REPLAY_DEPTH`+1 bytes.
- R10: During and right after reset, `tx_en` and `src_take` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Starts a frame when the block is idle |
| frame_retry | input | 1 | With `frame_start`: resend the first bytes from the replay store |
| frame_pad | input | 1 | With `frame_start`: pad the frame up to the minimum length |
| frame_crc | input | 1 | With `frame_start`: append the check sequence |
| min_len | input | LEN_W | Minimum frame length in bytes, address through check sequence |
| src_data | input | 8 | Next unsent byte from the source |
| src_last | input | 1 | Marks `src_data` as the frame's final byte |
| src_take | output | 1 | The source byte is consumed at this clock edge |
| collision | input | 1 | Aborts the frame at once |
| tx_en | output | 1 | Transmit enable to the line interface |
| tx_bit | output | 1 | Serial data bit |

## Verification
The bench aims at the points where the padding decision can go wrong. A frame shorter than the minimum must be padded, and a frame of exactly the minimum data length must not be. A design with an off-by-one in the length comparison would add or drop one whole 0x00 byte, and every check bit after it would then be wrong. Frames are run with the check sequence both on and off. A reversed bit order, a wrong seed or a missing complement shows up as bad trailing bits, and a trailing bit sent with `frame_crc` clear shows up as an extra bit while enable is still high. A collision in the middle of the payload is followed by a retry. A design that refetches the stored bytes would pulse `src_take` too often and send the wrong bytes. A design that ignores the abort would keep enable high. A start pulse sent in the middle of a frame would corrupt the stream if it were wrongly accepted.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_SFD,
        ST_DATA,
        ST_PAD,
        ST_FCS
    } tx_state_t;

    localparam logic [7:0]  PREAMBLE_BYTE = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam logic [7:0]  PAD_BYTE      = 8'h00;
    localparam int          FCS_BYTES     = 4;
    localparam int          FCS_BITS      = FCS_BYTES * 8;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        upd_en,
    input  logic        upd_bit,
    input  logic        out_en,
    output logic [31:0] crc_q
);

    logic feedback;
    assign feedback = crc_q[0] ^ upd_bit;

    // Reflected serial CRC while data goes out; plain right shift while the
    // complemented remainder is sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (init) begin
            crc_q <= CRC_SEED;
        end else if (upd_en) begin
            crc_q <= (crc_q >> 1) ^ (feedback ? CRC_POLY_REFL : 32'h0);
        end else if (out_en) begin
            crc_q <= {1'b1, crc_q[31:1]};
        end
    end

endmodule

// File: rtl/eth_tx_replay.sv
module eth_tx_replay #(
    parameter int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end

    assign rd_data = store[rd_idx];

endmodule

// File: rtl/eth_tx_serializer.sv
module eth_tx_serializer
    import eth_tx_pkg::*;
#(
    parameter int LEN_W        = 11,
    parameter int REPLAY_DEPTH = 8,
    parameter int PREAMBLE_LEN = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             frame_retry,
    input  logic             frame_pad,
    input  logic             frame_crc,
    input  logic [LEN_W-1:0] min_len,
    input  logic [7:0]       src_data,
    input  logic             src_last,
    output logic             src_take,
    input  logic             collision,
    output logic             tx_en,
    output logic             tx_bit
);

    localparam int IDX_W = (REPLAY_DEPTH > 1) ? $clog2(REPLAY_DEPTH) : 1;
    localparam int PRE_W = (PREAMBLE_LEN > 1) ? $clog2(PREAMBLE_LEN) : 1;
    localparam logic [LEN_W-1:0] REPLAY_LIM = LEN_W'(REPLAY_DEPTH);
    localparam logic [PRE_W-1:0] PRE_LAST   = PRE_W'(PREAMBLE_LEN - 1);

    tx_state_t        state, state_nx;
    logic [7:0]       shreg;
    logic [2:0]       bit_idx;
    logic [PRE_W-1:0] pre_cnt;
    logic [LEN_W-1:0] byte_cnt;
    logic [LEN_W-1:0] pad_target;
    logic [4:0]       fcs_cnt;
    logic             cur_last;
    logic             pad_en;
    logic             crc_en;
    logic             retry_q;

    logic        byte_end;
    logic        from_store;
    logic        need_fetch;
    logic        more_pad;
    logic [7:0]  fetch_data;
    logic        fetch_last;
    logic [7:0]  store_data;
    logic        store_wr;
    logic [31:0] crc_q;

    assign byte_end   = (bit_idx == 3'd7);
    assign from_store = retry_q && (byte_cnt < REPLAY_LIM);
    assign need_fetch = byte_end &&
                        ((state == ST_SFD) || (state == ST_DATA && !cur_last));
    assign more_pad   = pad_en && (byte_cnt < pad_target);
    assign fetch_data = from_store ? store_data : src_data;
    assign fetch_last = from_store ? 1'b0 : src_last;
    assign src_take   = need_fetch && !from_store && !collision;
    assign store_wr   = src_take && !retry_q && (byte_cnt < REPLAY_LIM);

    eth_tx_replay #(.DEPTH(REPLAY_DEPTH)) u_replay (
        .clk     (clk),
        .wr_en   (store_wr),
        .wr_idx  (byte_cnt[IDX_W-1:0]),
        .wr_data (src_data),
        .rd_idx  (byte_cnt[IDX_W-1:0]),
        .rd_data (store_data)
    );

    eth_tx_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (state == ST_IDLE && frame_start),
        .upd_en  (state == ST_DATA || state == ST_PAD),
        .upd_bit (shreg[0]),
        .out_en  (state == ST_FCS),
        .crc_q   (crc_q)
    );

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (frame_start) state_nx = ST_PREAMBLE;
            ST_PREAMBLE: if (byte_end && pre_cnt == PRE_LAST) state_nx = ST_SFD;
            ST_SFD:      if (byte_end) state_nx = ST_DATA;
            ST_DATA: begin
                if (byte_end && cur_last) begin
                    if (more_pad)    state_nx = ST_PAD;
                    else if (crc_en) state_nx = ST_FCS;
                    else             state_nx = ST_IDLE;
                end
            end
            ST_PAD: begin
                if (byte_end && !more_pad) state_nx = crc_en ? ST_FCS : ST_IDLE;
            end
            ST_FCS:      if (fcs_cnt == 5'(FCS_BITS - 1)) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
        if (collision && state != ST_IDLE) state_nx = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Shift register, counters and per-frame flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_idx    <= '0;
            pre_cnt    <= '0;
            byte_cnt   <= '0;
            pad_target <= '0;
            fcs_cnt    <= '0;
            cur_last   <= 1'b0;
            pad_en     <= 1'b0;
            crc_en     <= 1'b0;
            retry_q    <= 1'b0;
        end else if (state == ST_IDLE) begin
            bit_idx <= '0;
            if (frame_start) begin
                shreg      <= PREAMBLE_BYTE;
                pre_cnt    <= '0;
                byte_cnt   <= '0;
                fcs_cnt    <= '0;
                cur_last   <= 1'b0;
                pad_en     <= frame_pad;
                crc_en     <= frame_crc;
                retry_q    <= frame_retry;
                pad_target <= min_len - LEN_W'(FCS_BYTES);
            end
        end else begin
            bit_idx <= (state == ST_FCS) ? 3'd0 : bit_idx + 3'd1;
            shreg   <= shreg >> 1;
            if (state == ST_FCS) begin
                fcs_cnt <= fcs_cnt + 5'd1;
            end else if (byte_end) begin
                if (state == ST_PREAMBLE) begin
                    pre_cnt <= pre_cnt + PRE_W'(1);
                    shreg   <= (pre_cnt == PRE_LAST) ? SFD_BYTE : PREAMBLE_BYTE;
                end else if (need_fetch) begin
                    shreg    <= fetch_data;
                    cur_last <= fetch_last;
                    byte_cnt <= byte_cnt + LEN_W'(1);
                end else if (more_pad) begin
                    shreg    <= PAD_BYTE;
                    byte_cnt <= byte_cnt + LEN_W'(1);
                end
            end
        end
    end

    // Outputs
    always_comb begin
        tx_en  = (state != ST_IDLE);
        tx_bit = 1'b0;
        unique case (state)
            ST_IDLE: tx_bit = 1'b0;
            ST_FCS:  tx_bit = ~crc_q[0];
            default: tx_bit = shreg[0];
        endcase
    end

    AST_START_OPENS_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (state == ST_PREAMBLE && pre_cnt == '0 && bit_idx == 3'd0)); // R1

    AST_FCS_ONLY_WHEN_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FCS) |-> crc_en); // R4

    AST_END_FROM_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(tx_en) && !$past(collision)) |->
        ($past(state) == ST_FCS || $past(state) == ST_DATA || $past(state) == ST_PAD)); // R5

    AST_COLLISION_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (collision && tx_en) |=> !tx_en); // R8

    AST_REPLAY_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_q && byte_cnt < REPLAY_LIM && (state == ST_SFD || state == ST_DATA))
        |-> !src_take); // R9

endmodule

// File: tb/eth_tx_serializer_bench.sv
`timescale 1ns/1ps
module eth_tx_serializer_bench;

    localparam int LEN_W = 11;
    localparam int RD    = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic             frame_retry = 1'b0;
    logic             frame_pad = 1'b0;
    logic             frame_crc = 1'b0;
    logic [LEN_W-1:0] min_len = LEN_W'(64);
    logic [7:0]       src_data;
    logic             src_last;
    logic             src_take;
    logic             collision = 1'b0;
    logic             tx_en;
    logic             tx_bit;

    always #2.5 clk = ~clk;

    logic [7:0] src_mem [0:127];
    int src_len = 1;
    int src_base = 0;
    int src_mark = 0;
    int taken = 0;
    int src_ptr;
    assign src_ptr  = src_base + taken - src_mark;
    assign src_data = src_mem[src_ptr[6:0]];
    assign src_last = (src_ptr == src_len - 1);

    bit    exp_bits[$];
    string exp_tags[$];
    int    compared = 0;
    int    mismatched = 0;
    bit    abort_flag = 1'b0;
    bit    pend = 1'b0;
    bit    prev_en = 1'b0;
    int    cyc = 0;

    eth_tx_serializer #(.LEN_W(LEN_W), .REPLAY_DEPTH(RD)) u_eth_tx_serializer (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_retry(frame_retry),
        .frame_pad(frame_pad), .frame_crc(frame_crc), .min_len(min_len),
        .src_data(src_data), .src_last(src_last), .src_take(src_take),
        .collision(collision), .tx_en(tx_en), .tx_bit(tx_bit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input string tag);
        for (int i = 0; i < 8; i++) begin
            exp_bits.push_back(b[i]);
            exp_tags.push_back(tag);
        end
    endtask

    task automatic fill_source(input int len, input int seed);
        src_len = len;
        for (int i = 0; i < 128; i++) src_mem[i] = 8'((i * 37 + seed * 11 + 3) ^ (i >> 2));
    endtask

    // Driver: builds the expected bit stream from the requirements.
    task automatic push_frame(input int len, input bit pad, input bit crc,
                              input int minl, input string dtag);
        logic [31:0] c;
        logic        fb;
        logic [7:0]  b;
        logic [31:0] f;
        int          n;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 7; i++) push_byte(8'h55, "R1");
        push_byte(8'hD5, "R1");
        n = 0;
        while (n < len || (pad && n < minl - 4)) begin
            b = (n < len) ? src_mem[n] : 8'h00;
            push_byte(b, (n < len) ? dtag : "R3");
            for (int k = 0; k < 8; k++) begin
                fb = c[0] ^ b[k];
                c  = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
            n++;
        end
        if (crc) begin
            f = ~c;
            for (int k = 0; k < 4; k++) push_byte(f[8*k +: 8], "R4");
        end
    endtask

    task automatic start(input bit retry, input bit pad, input bit crc, input int minl);
        @(posedge clk); #1;
        frame_start = 1'b1; frame_retry = retry; frame_pad = pad; frame_crc = crc;
        min_len = LEN_W'(minl);
        @(posedge clk); #1;
        frame_start = 1'b0; frame_retry = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (exp_bits.size() != 0 || tx_en);
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input int len, input bit pad, input bit crc, input int minl,
                       input string dtag, input int seed);
        fill_source(len, seed);
        src_base = 0; src_mark = taken;
        push_frame(len, pad, crc, minl, dtag);
        start(1'b0, pad, crc, minl);
        wait_done();
        check(taken - src_mark == len, "R2 take count", taken - src_mark, len);
    endtask

    initial begin
        fork
            begin : monitor
                forever begin
                    @(negedge clk);
                    if (pend) taken++;
                    pend = src_take;
                    if (tx_en) begin
                        if (exp_bits.size() == 0) begin
                            check(1'b0, "R5 extra bit while enabled", 1, 0);
                        end else begin
                            bit    e;
                            string t;
                            e = exp_bits.pop_front();
                            t = exp_tags.pop_front();
                            check(tx_bit == e, t, int'(tx_bit), int'(e));
                        end
                    end
                    if (prev_en && !tx_en) begin
                        if (abort_flag) begin
                            check(1'b1, "R8", 0, 0);
                            exp_bits.delete();
                            exp_tags.delete();
                        end else begin
                            check(exp_bits.size() == 0, "R5 enable fell early",
                                  exp_bits.size(), 0);
                        end
                    end
                    prev_en = tx_en;
                end
            end
            begin : watchdog
                forever begin
                    @(posedge clk);
                    cyc++;
                    if (cyc > 150000) begin
                        check(1'b0, "watchdog expired", cyc, 150000);
                        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                                 compared, mismatched);
                        $finish;
                    end
                end
            end
        join_none

        fill_source(20, 0);
        repeat (4) @(negedge clk);
        // R10: quiet outputs during reset
        check(!tx_en && !src_take, "R10 in reset", int'(tx_en), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(!tx_en && !src_take, "R10 after reset", int'(tx_en), 0);

        // R3/R4: short frame padded to 60 bytes plus CRC
        run(20, 1'b1, 1'b1, 64, "R2", 1);
        // R6: long frame, no padding needed
        run(70, 1'b1, 1'b1, 64, "R6", 2);
        // R6: exact boundary, 60 source bytes with min 64
        run(60, 1'b1, 1'b1, 64, "R6", 3);
        // R6/R4: no padding, no CRC
        run(20, 1'b0, 1'b0, 64, "R6", 4);
        // R3: padding with a different minimum and no CRC
        run(30, 1'b1, 1'b0, 48, "R3", 5);

        // R7: start pulse in the middle of a frame is ignored
        fill_source(25, 6);
        src_base = 0; src_mark = taken;
        push_frame(25, 1'b1, 1'b1, 64, "R7");
        start(1'b0, 1'b1, 1'b1, 64);
        repeat (100) @(posedge clk);
        #1 frame_start = 1'b1; frame_pad = 1'b0; frame_crc = 1'b0;
        @(posedge clk); #1 frame_start = 1'b0;
        wait_done();

        // R8: collision mid-payload, then R9 retry from the replay store
        fill_source(40, 7);
        src_base = 0; src_mark = taken;
        push_frame(40, 1'b1, 1'b1, 64, "R2");
        start(1'b0, 1'b1, 1'b1, 64);
        repeat (160) @(posedge clk);
        #1 collision = 1'b1; abort_flag = 1'b1;
        @(posedge clk); #1 collision = 1'b0;
        @(negedge clk);
        check(!tx_en, "R8 enable after collision", int'(tx_en), 0);
        repeat (4) @(negedge clk);
        check(exp_bits.size() == 0, "R8 abort seen", exp_bits.size(), 0);
        abort_flag = 1'b0;
        check(taken - src_mark >= RD, "R9 first attempt fetched replay bytes",
              taken - src_mark, RD);
        src_base = RD; src_mark = taken;
        push_frame(40, 1'b1, 1'b1, 64, "R9");
        start(1'b1, 1'b1, 1'b1, 64);
        wait_done();
        check(taken - src_mark == 40 - RD, "R9 source fetches on retry",
              taken - src_mark, 40 - RD);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule